// File: doc/BRIEF.md
# PLL Power-Up Sequencer with Lock Retry

This block is a timed state machine that takes a PLL out of power-down. An accepted enable request starts a fixed sequence. It first pulses a reset bit. It then raises four power controls one at a time in a fixed order, each held for its own settle time: the power-down release, the power generator, the LDO and the PLL enable. Next it drops the lock-detect setting to a low code for a short window and then returns it to its armed code. Finally it polls a ready input a bounded number of times. The first high sample finishes the sequence with a sticky done flag.

If every poll misses, the block makes a second attempt. This attempt repeats the reset pulse and the power staircase, and it also briefly drops the LDO and raises it again before the enable step. If the last attempt also fails, a sticky fail flag is raised. A disable request turns every control off at once and aborts any sequence in progress.

All delays are counted in microseconds. A prescaler turns the system clock into a microsecond tick, and its division ratio is a parameter. The prescaler restarts with every step, so a step of N microseconds lasts exactly N times CYCLES_PER_US clock cycles.

Top module: `pll_pwrup_seq`

## Requirements
- R1: After reset the reset bit and all four power controls are 0, done and fail are 0, and the lock-detect code holds its armed value 0x0D.
- R2: An enable request is accepted only when no sequence is running (idle, locked or failed) and disable is low. On acceptance, done and fail clear, and the reset bit goes high for RST_US and then low for RST_US. The power controls keep their previous values for the whole pulse.
- R3: On the first attempt the power controls rise cumulatively in a fixed order. Power-down release alone is held for 1 us. Adding the generator gives 200 us. Adding the LDO gives 500 us. Adding the enable gives 600 us.
- R4: After the 600 us enable step, the lock-detect code is 0x0C for 100 us and then returns to 0x0D.
- R5: Ready is first sampled in the cycle after the code returns to 0x0D, and after each low sample a 100 us wait plus one cycle comes before the next sample. There are up to 5 samples. The first high sample sets done at the next edge, so done follows the return to 0x0D by 1 + k*(100 us + 1) cycles for sample index k.
- R6: When all 5 samples of a non-final attempt are low, a new reset pulse starts 100 us after the last sample, with all four power controls still high.
- R7: On a retry attempt, the LDO step lasts 250 us. The LDO then drops for 200 us while release and generator stay high. The LDO then returns for 500 us, and after that the enable is added for 600 us.
- R8: When the last of the 2 attempts fails, fail rises 100 us after the last sample. Done and fail are never high together.
- R9: A disable request clears the reset bit and all power controls at the next edge, restores code 0x0D and returns to idle. Disable wins over a simultaneous enable.
- R10: Done and fail stay high until an enable request is accepted. A disable request does not clear them.
- R11: An enable request during a running sequence has no effect on any output.
- R12: The enable is high only while the LDO, generator and release are high. The LDO is high only while the generator and release are high. The generator is high only while release is high.
- R13: Every delay of N microseconds lasts exactly N*CYCLES_PER_US clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_req | input | 1 | Start the power-up sequence |
| dis_req | input | 1 | Turn all controls off and abort |
| pll_ready | input | 1 | PLL ready status |
| sw_rst | output | 1 | PLL reset bit |
| pwrdn_rel | output | 1 | Power-down release |
| pwrgen_on | output | 1 | Power generator enable |
| ldo_on | output | 1 | LDO enable |
| pll_en | output | 1 | PLL enable |
| lkdet_code | output | LKDET_W | Lock-detect setting code |
| seq_done | output | 1 | Sticky lock success |
| seq_fail | output | 1 | Sticky lock failure |

## Verification
The assertions assume that enable and disable are synchronous single-cycle requests. They also assume that ready may take any value at any time, so the checks tie done only to the ready value seen at the sampling edge. The stimulus changes every input at falling edges. It raises ready at a cycle computed from the poll spacing, so that a chosen sample index locks, and it keeps ready steady in the other scenarios.

// File: rtl/pll_pwrup_pkg.sv
package pll_pwrup_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RST_ON,
      ST_RST_OFF,
      ST_STEP_PD,
      ST_STEP_GEN,
      ST_STEP_LDO,
      ST_LDO_DROP,
      ST_LDO_RAISE,
      ST_STEP_EN,
      ST_LKDET_LO,
      ST_SAMPLE,
      ST_POLL_WAIT,
      ST_LOCKED,
      ST_FAILED
   } seq_state_e;

   typedef struct packed {
      logic pd_rel;
      logic gen_on;
      logic ldo_on;
      logic pll_en;
   } pwr_ctl_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pll_pwrup_tick.sv
module pll_pwrup_tick #(
   parameter int CYC_PER_US = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   generate
      if (CYC_PER_US == 1) begin : g_direct
         logic unused_tick_in;
         assign unused_tick_in = restart ^ clk ^ rst_n;
         assign tick = 1'b1;
      end else begin : g_prescale
         localparam int PW = $clog2(CYC_PER_US);
         logic [PW-1:0] pre_q;
         assign tick = (pre_q == PW'(CYC_PER_US - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)              pre_q <= '0;
            else if (restart || tick) pre_q <= '0;
            else                     pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/pll_pwrup_timer.sv
module pll_pwrup_timer #(
   parameter int CYC_PER_US = 50,
   parameter int DLY_W      = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] load_val,
   output logic             expire
);
   logic             tick;
   logic [DLY_W-1:0] rem_q;

   pll_pwrup_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load),
      .tick    (tick)
   );

   assign expire = tick && (rem_q == DLY_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)                          rem_q <= '0;
      else if (load)                       rem_q <= load_val;
      else if (tick && (rem_q != '0))      rem_q <= rem_q - 1'b1;
   end
endmodule

// File: rtl/pll_pwrup_fsm.sv
module pll_pwrup_fsm
   import pll_pwrup_pkg::*;
#(
   parameter int DLY_W            = 10,
   parameter int RST_US           = 1,
   parameter int PD_US            = 1,
   parameter int GEN_US           = 200,
   parameter int LDO_US           = 500,
   parameter int LDO_RETRY_US     = 250,
   parameter int LDO_OFF_US       = 200,
   parameter int LDO_ON_US        = 500,
   parameter int EN_US            = 600,
   parameter int LKDET_LO_US      = 100,
   parameter int POLL_US          = 100,
   parameter int POLL_MAX         = 5,
   parameter int ATTEMPTS         = 2,
   parameter int LKDET_W          = 8,
   parameter int LKDET_LO_CODE    = 12,
   parameter int LKDET_ARMED_CODE = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_req,
   input  logic               dis_req,
   input  logic               pll_ready,
   input  logic               expire,
   output logic               load,
   output logic [DLY_W-1:0]   load_val,
   output logic               sw_rst,
   output pwr_ctl_t           pwr,
   output logic [LKDET_W-1:0] lkdet,
   output logic               done,
   output logic               fail
);
   localparam int AW = $clog2(ATTEMPTS) + 1;
   localparam int PW = $clog2(POLL_MAX + 1);
   localparam logic [LKDET_W-1:0] LK_LO  = LKDET_W'(LKDET_LO_CODE);
   localparam logic [LKDET_W-1:0] LK_ARM = LKDET_W'(LKDET_ARMED_CODE);

   seq_state_e         st_q, st_n;
   pwr_ctl_t           pwr_q, pwr_n;
   logic               sw_q, sw_n;
   logic [LKDET_W-1:0] lk_q, lk_n;
   logic               done_q, done_n, fail_q, fail_n;
   logic [AW-1:0]      att_q, att_n;
   logic [PW-1:0]      poll_q, poll_n;

   always_comb begin
      st_n     = st_q;
      pwr_n    = pwr_q;
      sw_n     = sw_q;
      lk_n     = lk_q;
      done_n   = done_q;
      fail_n   = fail_q;
      att_n    = att_q;
      poll_n   = poll_q;
      load     = 1'b0;
      load_val = '0;
      if (dis_req) begin
         st_n  = ST_IDLE;
         pwr_n = '0;
         sw_n  = 1'b0;
         lk_n  = LK_ARM;
      end else begin
         unique case (st_q)
            ST_IDLE, ST_LOCKED, ST_FAILED: begin
               if (en_req) begin
                  st_n     = ST_RST_ON;
                  sw_n     = 1'b1;
                  done_n   = 1'b0;
                  fail_n   = 1'b0;
                  att_n    = '0;
                  load     = 1'b1;
                  load_val = DLY_W'(RST_US);
               end
            end
            ST_RST_ON: if (expire) begin
               st_n     = ST_RST_OFF;
               sw_n     = 1'b0;
               load     = 1'b1;
               load_val = DLY_W'(RST_US);
            end
            ST_RST_OFF: if (expire) begin
               st_n         = ST_STEP_PD;
               pwr_n        = '0;
               pwr_n.pd_rel = 1'b1;
               load         = 1'b1;
               load_val     = DLY_W'(PD_US);
            end
            ST_STEP_PD: if (expire) begin
               st_n         = ST_STEP_GEN;
               pwr_n.gen_on = 1'b1;
               load         = 1'b1;
               load_val     = DLY_W'(GEN_US);
            end
            ST_STEP_GEN: if (expire) begin
               st_n         = ST_STEP_LDO;
               pwr_n.ldo_on = 1'b1;
               load         = 1'b1;
               load_val     = (att_q == '0) ? DLY_W'(LDO_US) : DLY_W'(LDO_RETRY_US);
            end
            ST_STEP_LDO: if (expire) begin
               load = 1'b1;
               if (att_q != '0) begin
                  st_n         = ST_LDO_DROP;
                  pwr_n.ldo_on = 1'b0;
                  load_val     = DLY_W'(LDO_OFF_US);
               end else begin
                  st_n         = ST_STEP_EN;
                  pwr_n.pll_en = 1'b1;
                  load_val     = DLY_W'(EN_US);
               end
            end
            ST_LDO_DROP: if (expire) begin
               st_n         = ST_LDO_RAISE;
               pwr_n.ldo_on = 1'b1;
               load         = 1'b1;
               load_val     = DLY_W'(LDO_ON_US);
            end
            ST_LDO_RAISE: if (expire) begin
               st_n         = ST_STEP_EN;
               pwr_n.pll_en = 1'b1;
               load         = 1'b1;
               load_val     = DLY_W'(EN_US);
            end
            ST_STEP_EN: if (expire) begin
               st_n     = ST_LKDET_LO;
               lk_n     = LK_LO;
               load     = 1'b1;
               load_val = DLY_W'(LKDET_LO_US);
            end
            ST_LKDET_LO: if (expire) begin
               st_n   = ST_SAMPLE;
               lk_n   = LK_ARM;
               poll_n = '0;
            end
            ST_SAMPLE: begin
               if (pll_ready) begin
                  st_n   = ST_LOCKED;
                  done_n = 1'b1;
               end else begin
                  st_n     = ST_POLL_WAIT;
                  poll_n   = poll_q + 1'b1;
                  load     = 1'b1;
                  load_val = DLY_W'(POLL_US);
               end
            end
            ST_POLL_WAIT: if (expire) begin
               if (poll_q == PW'(POLL_MAX)) begin
                  if (att_q == AW'(ATTEMPTS - 1)) begin
                     st_n   = ST_FAILED;
                     fail_n = 1'b1;
                  end else begin
                     st_n     = ST_RST_ON;
                     sw_n     = 1'b1;
                     att_n    = att_q + 1'b1;
                     load     = 1'b1;
                     load_val = DLY_W'(RST_US);
                  end
               end else begin
                  st_n = ST_SAMPLE;
               end
            end
            default: st_n = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pwr_q  <= '0;
         sw_q   <= 1'b0;
         lk_q   <= LK_ARM;
         done_q <= 1'b0;
         fail_q <= 1'b0;
         att_q  <= '0;
         poll_q <= '0;
      end else begin
         st_q   <= st_n;
         pwr_q  <= pwr_n;
         sw_q   <= sw_n;
         lk_q   <= lk_n;
         done_q <= done_n;
         fail_q <= fail_n;
         att_q  <= att_n;
         poll_q <= poll_n;
      end
   end

   assign sw_rst = sw_q;
   assign pwr    = pwr_q;
   assign lkdet  = lk_q;
   assign done   = done_q;
   assign fail   = fail_q;
endmodule

// File: rtl/pll_pwrup_seq.sv
module pll_pwrup_seq
   import pll_pwrup_pkg::*;
#(
   parameter int CYCLES_PER_US    = 50,
   parameter int RST_US           = 1,
   parameter int PD_US            = 1,
   parameter int GEN_US           = 200,
   parameter int LDO_US           = 500,
   parameter int LDO_RETRY_US     = 250,
   parameter int LDO_OFF_US       = 200,
   parameter int LDO_ON_US        = 500,
   parameter int EN_US            = 600,
   parameter int LKDET_LO_US      = 100,
   parameter int POLL_US          = 100,
   parameter int POLL_MAX         = 5,
   parameter int ATTEMPTS         = 2,
   parameter int LKDET_W          = 8,
   parameter int LKDET_LO_CODE    = 12,
   parameter int LKDET_ARMED_CODE = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_req,
   input  logic               dis_req,
   input  logic               pll_ready,
   output logic               sw_rst,
   output logic               pwrdn_rel,
   output logic               pwrgen_on,
   output logic               ldo_on,
   output logic               pll_en,
   output logic [LKDET_W-1:0] lkdet_code,
   output logic               seq_done,
   output logic               seq_fail
);
   localparam int DLY_MAX = max2(max2(max2(RST_US, PD_US), max2(GEN_US, LDO_US)),
                                 max2(max2(LDO_RETRY_US, LDO_OFF_US),
                                      max2(max2(LDO_ON_US, EN_US), max2(LKDET_LO_US, POLL_US))));
   localparam int DLY_W = $clog2(DLY_MAX + 1);

   generate
      if (CYCLES_PER_US < 1) begin : g_bad_cpu
         $error("CYCLES_PER_US must be at least 1");
      end
      if (RST_US < 1 || PD_US < 1 || GEN_US < 1 || LDO_US < 1 || LDO_RETRY_US < 1 ||
          LDO_OFF_US < 1 || LDO_ON_US < 1 || EN_US < 1 || LKDET_LO_US < 1 || POLL_US < 1) begin : g_bad_dly
         $error("every delay must be at least 1 us");
      end
      if (POLL_MAX < 1 || ATTEMPTS < 1) begin : g_bad_cnt
         $error("POLL_MAX and ATTEMPTS must be at least 1");
      end
      if (LKDET_LO_CODE >= (1 << LKDET_W) || LKDET_ARMED_CODE >= (1 << LKDET_W) ||
          LKDET_LO_CODE == LKDET_ARMED_CODE) begin : g_bad_code
         $error("lock-detect codes must fit LKDET_W and differ");
      end
   endgenerate

   logic             load, expire;
   logic [DLY_W-1:0] load_val;
   pwr_ctl_t         pwr;

   pll_pwrup_timer #(.CYC_PER_US(CYCLES_PER_US), .DLY_W(DLY_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .expire   (expire)
   );

   pll_pwrup_fsm #(
      .DLY_W(DLY_W), .RST_US(RST_US), .PD_US(PD_US), .GEN_US(GEN_US),
      .LDO_US(LDO_US), .LDO_RETRY_US(LDO_RETRY_US), .LDO_OFF_US(LDO_OFF_US),
      .LDO_ON_US(LDO_ON_US), .EN_US(EN_US), .LKDET_LO_US(LKDET_LO_US),
      .POLL_US(POLL_US), .POLL_MAX(POLL_MAX), .ATTEMPTS(ATTEMPTS),
      .LKDET_W(LKDET_W), .LKDET_LO_CODE(LKDET_LO_CODE), .LKDET_ARMED_CODE(LKDET_ARMED_CODE)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_req    (en_req),
      .dis_req   (dis_req),
      .pll_ready (pll_ready),
      .expire    (expire),
      .load      (load),
      .load_val  (load_val),
      .sw_rst    (sw_rst),
      .pwr       (pwr),
      .lkdet     (lkdet_code),
      .done      (seq_done),
      .fail      (seq_fail)
   );

   assign pwrdn_rel = pwr.pd_rel;
   assign pwrgen_on = pwr.gen_on;
   assign ldo_on    = pwr.ldo_on;
   assign pll_en    = pwr.pll_en;
endmodule

// File: rtl/pll_pwrup_seq_chk.sv
module pll_pwrup_seq_chk #(
   parameter int LKDET_W          = 8,
   parameter int LKDET_LO_CODE    = 12,
   parameter int LKDET_ARMED_CODE = 13
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en_req,
   input logic               dis_req,
   input logic               pll_ready,
   input logic               sw_rst,
   input logic               pwrdn_rel,
   input logic               pwrgen_on,
   input logic               ldo_on,
   input logic               pll_en,
   input logic [LKDET_W-1:0] lkdet_code,
   input logic               seq_done,
   input logic               seq_fail
);
   localparam logic [LKDET_W-1:0] LK_LO  = LKDET_W'(LKDET_LO_CODE);
   localparam logic [LKDET_W-1:0] LK_ARM = LKDET_W'(LKDET_ARMED_CODE);

   assert_stair_en_R12: assert property (@(posedge clk) disable iff (!rst_n)
      pll_en |-> (ldo_on && pwrgen_on && pwrdn_rel));

   assert_stair_ldo_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ldo_on |-> (pwrgen_on && pwrdn_rel));

   assert_stair_gen_R12: assert property (@(posedge clk) disable iff (!rst_n)
      pwrgen_on |-> pwrdn_rel);

   assert_all_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dis_req |=> (!sw_rst && !pwrdn_rel && !pwrgen_on && !ldo_on && !pll_en && lkdet_code == LK_ARM));

   assert_lock_seen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_done) |-> $past(pll_ready));

   assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(seq_done && seq_fail));

   assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && !en_req) |=> seq_done);

   assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_fail && !en_req) |=> seq_fail);

   assert_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lkdet_code == LK_LO) || (lkdet_code == LK_ARM));

   assert_pulse_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_rst && $past(sw_rst)) |-> $stable({pwrdn_rel, pwrgen_on, ldo_on, pll_en}));
endmodule

bind pll_pwrup_seq pll_pwrup_seq_chk #(
   .LKDET_W(LKDET_W), .LKDET_LO_CODE(LKDET_LO_CODE), .LKDET_ARMED_CODE(LKDET_ARMED_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req), .pll_ready(pll_ready),
   .sw_rst(sw_rst), .pwrdn_rel(pwrdn_rel), .pwrgen_on(pwrgen_on), .ldo_on(ldo_on),
   .pll_en(pll_en), .lkdet_code(lkdet_code), .seq_done(seq_done), .seq_fail(seq_fail)
);

// File: tb/pll_pwrup_seq_bench.sv
module pll_pwrup_seq_bench;
   localparam int CPU = 2;
   localparam int W   = 100 * CPU;
   localparam logic [7:0] LO  = 8'h0C;
   localparam logic [7:0] ARM = 8'h0D;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_req = 1'b0, dis_req = 1'b0, pll_ready = 1'b0;
   logic sw_rst, pwrdn_rel, pwrgen_on, ldo_on, pll_en, seq_done, seq_fail;
   logic [7:0] lkdet_code;

   always #10 clk = ~clk;

   pll_pwrup_seq #(.CYCLES_PER_US(CPU)) u_pll_pwrup_seq (
      .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req), .pll_ready(pll_ready),
      .sw_rst(sw_rst), .pwrdn_rel(pwrdn_rel), .pwrgen_on(pwrgen_on), .ldo_on(ldo_on),
      .pll_en(pll_en), .lkdet_code(lkdet_code), .seq_done(seq_done), .seq_fail(seq_fail)
   );

   typedef struct {
      logic [14:0] v;
      int          d;
      string       r;
   } exp_t;

   exp_t        q[$];
   int          n_chk = 0, n_fail = 0;
   longint      cyc = 0, last = 0;
   logic [14:0] prev;
   bit          finished = 0;

   wire [14:0] obs = {sw_rst, pwrdn_rel, pwrgen_on, ldo_on, pll_en, lkdet_code, seq_done, seq_fail};

   function automatic logic [14:0] mk(input logic [3:0] pb, input logic sr, input logic [7:0] lk,
                                      input logic dn, input logic fl);
      return {sr, pb, lk, dn, fl};
   endfunction

   task automatic check(input bit ok, input string r, input string what, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", r, what, act, exp);
      end
   endtask

   task automatic push(input logic [14:0] v, input int d, input string r);
      exp_t e;
      e.v = v; e.d = d; e.r = r;
      q.push_back(e);
   endtask

   task automatic exp_start(input logic [3:0] pb, input bit retry, input int first_d, input string first_r);
      push(mk(pb, 1'b1, ARM, 1'b0, 1'b0), first_d, first_r);
      push(mk(pb, 1'b0, ARM, 1'b0, 1'b0), 1 * CPU, "R2");
      push(mk(4'b1000, 1'b0, ARM, 1'b0, 1'b0), 1 * CPU, "R2");
      push(mk(4'b1100, 1'b0, ARM, 1'b0, 1'b0), 1 * CPU, "R3");
      push(mk(4'b1110, 1'b0, ARM, 1'b0, 1'b0), 200 * CPU, "R3");
      if (retry) begin
         push(mk(4'b1100, 1'b0, ARM, 1'b0, 1'b0), 250 * CPU, "R7");
         push(mk(4'b1110, 1'b0, ARM, 1'b0, 1'b0), 200 * CPU, "R7");
         push(mk(4'b1111, 1'b0, ARM, 1'b0, 1'b0), 500 * CPU, "R7");
      end else begin
         push(mk(4'b1111, 1'b0, ARM, 1'b0, 1'b0), 500 * CPU, "R3");
      end
      push(mk(4'b1111, 1'b0, LO, 1'b0, 1'b0), 600 * CPU, retry ? "R7" : "R3");
      push(mk(4'b1111, 1'b0, ARM, 1'b0, 1'b0), 100 * CPU, "R4");
   endtask

   task automatic exp_lock(input int k);
      push(mk(4'b1111, 1'b0, ARM, 1'b1, 1'b0), 1 + k * (W + 1), "R5");
   endtask

   task automatic pulse_en();
      @(negedge clk) en_req = 1'b1;
      @(negedge clk) en_req = 1'b0;
   endtask

   task automatic pulse_dis();
      @(negedge clk) dis_req = 1'b1;
      @(negedge clk) dis_req = 1'b0;
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      repeat (20) @(negedge clk);
   endtask

   task automatic wait_armed();
      while (lkdet_code != LO) @(negedge clk);
      while (lkdet_code != ARM) @(negedge clk);
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // scoreboard monitor
   initial begin
      exp_t e;
      @(posedge rst_n);
      @(negedge clk);
      prev = obs;
      last = cyc;
      forever begin
         @(negedge clk);
         if (obs != prev) begin
            if (q.size() == 0) begin
               check(1'b0, "R11", "unexpected output change", longint'(obs), longint'(prev));
            end else begin
               e = q.pop_front();
               check(obs == e.v, e.r, "output vector", longint'(obs), longint'(e.v));
               if (e.d >= 0)
                  check((cyc - last) == longint'(e.d), {e.r, "/R13"}, "step duration", cyc - last, longint'(e.d));
            end
            prev = obs;
            last = cyc;
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired, actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(obs == mk(4'b0000, 1'b0, ARM, 1'b0, 1'b0), "R1", "reset outputs",
            longint'(obs), longint'(mk(4'b0000, 1'b0, ARM, 1'b0, 1'b0)));

      // lock on first sample, first attempt (R2 R3 R4 R5)
      pll_ready = 1'b1;
      exp_start(4'b0000, 1'b0, -1, "R2");
      exp_lock(0);
      pulse_en();
      drain();
      repeat (50) @(negedge clk);
      check(seq_done == 1'b1, "R10", "done held while idle", longint'(seq_done), 1);

      // restart from locked, ignored enable mid-run (R10 R11)
      exp_start(4'b1111, 1'b0, -1, "R10");
      exp_lock(0);
      pulse_en();
      repeat (300) @(negedge clk);
      pulse_en();   // R11: must change nothing
      drain();

      // first attempt fails, retry locks on sample 2 (R6 R7 R5)
      pll_ready = 1'b0;
      exp_start(4'b1111, 1'b0, -1, "R2");
      exp_start(4'b1111, 1'b1, 5 * W + 5, "R6");
      exp_lock(2);
      pulse_en();
      wait_armed();
      wait_armed();
      repeat (2 * W + 2) @(negedge clk);
      pll_ready = 1'b1;
      drain();
      pll_ready = 1'b0;

      // both attempts fail (R8)
      exp_start(4'b1111, 1'b0, -1, "R2");
      exp_start(4'b1111, 1'b1, 5 * W + 5, "R6");
      push(mk(4'b1111, 1'b0, ARM, 1'b0, 1'b1), 5 * W + 5, "R8");
      pulse_en();
      drain();
      check(seq_fail == 1'b1, "R8", "fail flag", longint'(seq_fail), 1);
      check(seq_done == 1'b0, "R8", "done low on failure", longint'(seq_done), 0);
      repeat (100) @(negedge clk);
      check(seq_fail == 1'b1, "R10", "fail held while idle", longint'(seq_fail), 1);

      // enable after failure clears fail and locks (R10)
      pll_ready = 1'b1;
      exp_start(4'b1111, 1'b0, -1, "R10");
      exp_lock(0);
      pulse_en();
      drain();

      // disable while locked: bits off, done kept (R9 R10)
      push(mk(4'b0000, 1'b0, ARM, 1'b1, 1'b0), -1, "R9");
      pulse_dis();
      drain();
      check(seq_done == 1'b1, "R10", "done kept after disable", longint'(seq_done), 1);

      // enable and disable together: disable wins (R9)
      @(negedge clk) begin en_req = 1'b1; dis_req = 1'b1; end
      @(negedge clk) begin en_req = 1'b0; dis_req = 1'b0; end
      repeat (20) @(negedge clk);
      check({sw_rst, pwrdn_rel, pwrgen_on, ldo_on, pll_en} == 5'b0, "R9", "enable with disable",
            longint'({sw_rst, pwrdn_rel, pwrgen_on, ldo_on, pll_en}), 0);

      // disable during the generator step aborts (R9)
      push(mk(4'b0000, 1'b1, ARM, 1'b0, 1'b0), -1, "R2");
      push(mk(4'b0000, 1'b0, ARM, 1'b0, 1'b0), 1 * CPU, "R2");
      push(mk(4'b1000, 1'b0, ARM, 1'b0, 1'b0), 1 * CPU, "R3");
      push(mk(4'b1100, 1'b0, ARM, 1'b0, 1'b0), 1 * CPU, "R3");
      push(mk(4'b0000, 1'b0, ARM, 1'b0, 1'b0), -1, "R9");
      pulse_en();
      repeat (100) @(negedge clk);
      pulse_dis();
      drain();
      repeat (2000) @(negedge clk);
      check(seq_done == 1'b0 && seq_fail == 1'b0, "R9", "idle after abort",
            longint'({seq_done, seq_fail}), 0);

      check(q.size() == 0, "R11", "pending expected items", longint'(q.size()), 0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule